// File: doc/BRIEF.md
# Runtime-Programmable Period Divider

The block turns a free-running clock into a periodic one-cycle pulse whose spacing, in enabled clock cycles, is a divide ratio N held in a register. The host writes that register at any time with a one-cycle strobe and a data word. A per-write flag decides how the new ratio applies. It can wait for the running period to finish, or it can apply at once.

Three counting styles are available and are picked by a two-bit select that is applied at reset. The first is a signed down-counter that ends a period when its sign bit sets. The second is an up-counter started from a negative value that ends a period on reaching zero. The third is an up-counter from zero that ends a period when it reaches or passes a stored limit. In every style the counter is one bit wider than the ratio field. A count enable pauses the counter without losing its place. Parameters set whether the output pulse comes from a flop or straight from the terminal logic, and which level is the active one.

Top module: `period_divider`

## Requirements
- R1: With `style_sel` = 0, the counter is loaded with N-2 and counts down. A period ends on the enabled cycle the counter reads -1. Pulses are N enabled cycles apart, and the counter never goes below -1.
- R2: With `style_sel` = 1, the counter is loaded with -(N-1) and counts up. A period ends on the enabled cycle it reads 0. Pulses are N enabled cycles apart, and the counter is never above 0.
- R3: With `style_sel` = 2 or 3, the counter starts at 0 and counts up. A period ends when the counter is greater than or equal to the active limit N-1. Pulses are N enabled cycles apart, and the counter stays non-negative.
- R4: A write with `apply_now` = 0 leaves the running period at its old length. The new N governs every period after the next wrap. This holds in all styles.
- R5: A write with `apply_now` = 1 in style 0 or 1 reloads the counter on the write cycle. The next pulse comes N_new enabled cycles after the write cycle.
- R6: A write that lands on the same cycle as a wrap still lets the pulse for the ending period occur. The new N then governs the very next period, whether the write is deferred or immediate.
- R7: A write with `apply_now` = 1 in style 2 or 3 changes the active limit without reloading the counter. If the count already meets the new limit, a wrap occurs on the next enabled cycle rather than after a run to full scale.
- R8: While `cnt_en` = 0 the counter holds its value and no pulse occurs. Period writes are still accepted, so a period that is paused for k cycles lasts N+k cycles.
- R9: Reset is synchronous and active high. It loads both period registers with `DEF_PERIOD` and loads the counter for the style on `style_sel`, so the first pulse comes `DEF_PERIOD` cycles after reset is released. The pulse output is inactive during reset. `style_sel` is changed only while reset is asserted.
- R10: A written or default ratio below 2 is taken as 2, so pulses are then 2 cycles apart.
- R11: With the default parameters, `tick` is active high and registered. It is high for exactly one cycle per period, on the cycle after the wrap. Two pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; low pauses the counter |
| wr_stb | input | 1 | One-cycle strobe that writes `wr_period` |
| wr_period | input | PER_W | New divide ratio N |
| apply_now | input | 1 | 1: the write applies at once; 0: it waits for the next wrap |
| style_sel | input | 2 | 0 sign-bit down-count, 1 negative up-count, 2/3 limit compare |
| tick | output | 1 | Terminal pulse, one cycle per period |

## Verification
The assertions assume that `style_sel` changes only while `rst` is high. The counter range checks and the stability check depend on the counter having been loaded for the style in force. The stimulus therefore picks each style in the same cycle that it raises reset, and holds the style until the next reset. Ratio writes may come at any phase. This includes a write on the wrap cycle and writes while the count is paused, because the properties on the period registers and the counter cover those cases as well.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    localparam int MIN_DIV = 2;

    typedef enum logic [1:0] {
        STY_SIGN  = 2'd0,
        STY_NEGUP = 2'd1,
        STY_LIMIT = 2'd2
    } style_e;

    typedef struct packed {
        logic load_imm;
        logic wrap;
        logic step;
    } cnt_ctl_t;

    function automatic style_e decode_style(input logic [1:0] code);
        case (code)
            2'd0:    return STY_SIGN;
            2'd1:    return STY_NEGUP;
            default: return STY_LIMIT;
        endcase
    endfunction

endpackage

// File: rtl/pdiv_period_regs.sv
module pdiv_period_regs
    import pdiv_pkg::*;
#(
    parameter int PER_W      = 8,
    parameter int DEF_PERIOD = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [PER_W-1:0] wr_period,
    input  logic             apply_now,
    input  logic             wrap,
    output logic [PER_W-1:0] act_per,
    output logic [PER_W-1:0] nxt_per,
    output logic [PER_W-1:0] imm_per,
    output logic             imm_load
);

    localparam logic [PER_W-1:0] MIN_V  = PER_W'(MIN_DIV);
    localparam logic [PER_W-1:0] DEF_CL = (DEF_PERIOD < MIN_DIV) ? MIN_V : PER_W'(DEF_PERIOD);

    logic [PER_W-1:0] pend_q;
    logic [PER_W-1:0] act_q;
    logic [PER_W-1:0] wr_clamped;

    always_comb begin
        wr_clamped = (wr_period < MIN_V) ? MIN_V : wr_period;
        nxt_per    = wr_stb ? wr_clamped : pend_q;
        imm_load   = wr_stb & apply_now;
        imm_per    = wr_clamped;
        act_per    = act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= DEF_CL;
        end else if (wr_stb) begin
            pend_q <= wr_clamped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= DEF_CL;
        end else if (imm_load) begin
            act_q <= wr_clamped;
        end else if (wrap) begin
            act_q <= nxt_per;
        end
    end

    AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (act_q >= MIN_V) && (pend_q >= MIN_V)); // R10

    AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !apply_now && !wrap) |=> $stable(act_q)); // R4

endmodule

// File: rtl/pdiv_count_core.sv
module pdiv_count_core
    import pdiv_pkg::*;
#(
    parameter int PER_W      = 8,
    parameter int DEF_PERIOD = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  style_e           style,
    input  logic [PER_W-1:0] act_per,
    input  logic [PER_W-1:0] nxt_per,
    input  logic [PER_W-1:0] imm_per,
    input  logic             imm_load,
    output logic             wrap
);

    localparam int               CW     = PER_W + 1;
    localparam logic [PER_W-1:0] DEF_CL = (DEF_PERIOD < MIN_DIV) ? PER_W'(MIN_DIV)
                                                                 : PER_W'(DEF_PERIOD);

    function automatic logic [CW-1:0] start_of(input style_e s, input logic [PER_W-1:0] n);
        case (s)
            STY_SIGN:  return {1'b0, n} - CW'(2);
            STY_NEGUP: return CW'(1) - {1'b0, n};
            default:   return '0;
        endcase
    endfunction

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          term;
    cnt_ctl_t      ctl;

    always_comb begin
        case (style)
            STY_SIGN:  term = cnt_q[CW-1];
            STY_NEGUP: term = (cnt_q == '0);
            default:   term = (cnt_q >= ({1'b0, act_per} - CW'(1)));
        endcase
    end

    assign wrap = cnt_en & term;

    always_comb begin
        ctl.load_imm = imm_load & (style != STY_LIMIT);
        ctl.wrap     = wrap;
        ctl.step     = cnt_en;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (ctl.load_imm) begin
            cnt_d = start_of(style, imm_per);
        end else if (ctl.wrap) begin
            cnt_d = start_of(style, nxt_per);
        end else if (ctl.step) begin
            cnt_d = (style == STY_SIGN) ? cnt_q - CW'(1) : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= start_of(style, DEF_CL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_SIGN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (style == STY_SIGN) |-> ($signed(cnt_q) >= $signed({CW{1'b1}}))); // R1

    AST_NEG_CEIL: assert property (@(posedge clk) disable iff (rst)
        (style == STY_NEGUP) |-> ((cnt_q == '0) || cnt_q[CW-1])); // R2

    AST_LIMIT_SIGN: assert property (@(posedge clk) disable iff (rst)
        (style == STY_LIMIT) |-> !cnt_q[CW-1]); // R3

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !imm_load) |=> $stable(cnt_q)); // R8

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap); // R11

endmodule

// File: rtl/pdiv_tick_out.sv
module pdiv_tick_out #(
    parameter bit TC_REGISTERED = 1'b1,
    parameter bit TC_ACTIVE_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    output logic tick
);

    logic lvl;

    generate
        if (TC_REGISTERED) begin : g_reg
            logic tick_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    tick_q <= 1'b0;
                end else begin
                    tick_q <= wrap;
                end
            end
            assign lvl = tick_q;
        end else begin : g_comb
            assign lvl = wrap;
        end
    endgenerate

    assign tick = TC_ACTIVE_LOW ? ~lvl : lvl;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (tick != TC_ACTIVE_LOW) |=> (tick == TC_ACTIVE_LOW)); // R11

endmodule

// File: rtl/period_divider.sv
module period_divider
    import pdiv_pkg::*;
#(
    parameter int PER_W         = 8,
    parameter int DEF_PERIOD    = 10,
    parameter bit TC_REGISTERED = 1'b1,
    parameter bit TC_ACTIVE_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             wr_stb,
    input  logic [PER_W-1:0] wr_period,
    input  logic             apply_now,
    input  logic [1:0]       style_sel,
    output logic             tick
);

    style_e           style;
    logic [PER_W-1:0] act_per;
    logic [PER_W-1:0] nxt_per;
    logic [PER_W-1:0] imm_per;
    logic             imm_load;
    logic             wrap;

    assign style = decode_style(style_sel);

    pdiv_period_regs #(
        .PER_W      (PER_W),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (wr_stb),
        .wr_period (wr_period),
        .apply_now (apply_now),
        .wrap      (wrap),
        .act_per   (act_per),
        .nxt_per   (nxt_per),
        .imm_per   (imm_per),
        .imm_load  (imm_load)
    );

    pdiv_count_core #(
        .PER_W      (PER_W),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .style    (style),
        .act_per  (act_per),
        .nxt_per  (nxt_per),
        .imm_per  (imm_per),
        .imm_load (imm_load),
        .wrap     (wrap)
    );

    pdiv_tick_out #(
        .TC_REGISTERED (TC_REGISTERED),
        .TC_ACTIVE_LOW (TC_ACTIVE_LOW)
    ) u_out (
        .clk  (clk),
        .rst  (rst),
        .wrap (wrap),
        .tick (tick)
    );

    AST_STYLE_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(style_sel)); // R9

endmodule

// File: tb/period_divider_test.sv
`timescale 1ns/1ps
module period_divider_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en;
    logic       wr_stb;
    logic [7:0] wr_period;
    logic       apply_now;
    logic [1:0] style_sel;
    logic       tick;

    int cyc    = 0;
    int checks = 0;
    int errors = 0;
    int wide   = 0;
    logic prev_hi = 1'b0;

    localparam int DEF_N = 10;

    always #2.5 clk = ~clk;

    period_divider #(
        .PER_W         (8),
        .DEF_PERIOD    (DEF_N),
        .TC_REGISTERED (1'b1),
        .TC_ACTIVE_LOW (1'b0)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .wr_stb    (wr_stb),
        .wr_period (wr_period),
        .apply_now (apply_now),
        .style_sel (style_sel),
        .tick      (tick)
    );

    // cycle counter and adjacent-pulse monitor (R11)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && tick === 1'b1 && prev_hi === 1'b1) wide <= wide + 1;
        prev_hi <= tick;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go_reset(input int s, input bit imm, output int rel);
        @(negedge clk);
        rst = 1'b1; style_sel = s[1:0]; apply_now = imm; wr_stb = 1'b0; cnt_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 tick idle in reset", int'(tick), 0);
        rst = 1'b0;
        rel = cyc;
    endtask

    task automatic wait_tick(output int c);
        do @(negedge clk); while (tick !== 1'b1);
        c = cyc;
    endtask

    task automatic write_per(input int n, input bit imm, output int wc, output bit saw);
        wr_stb = 1'b1; wr_period = n[7:0]; apply_now = imm;
        @(negedge clk);
        wc = cyc; saw = (tick === 1'b1);
        wr_stb = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (R1 to R11 flow): actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rel, t, t1, t2, t3, wc, hits;
        bit saw;
        string rq;
        rst = 1'b1; cnt_en = 1'b1; wr_stb = 1'b0; wr_period = '0;
        style_sel = 2'd0; apply_now = 1'b0;
        repeat (3) @(posedge clk);

        for (int s = 0; s < 3; s++) begin
            rq = (s == 0) ? "R1 sign style" : (s == 1) ? "R2 neg style" : "R3 limit style";

            // R9: first period after reset has the default length
            go_reset(s, 1'b0, rel);
            wait_tick(t);
            check("R9 first period", t - rel, DEF_N);

            // sweep of ratios, deferred writes
            for (int n = 2; n <= 12; n++) begin
                write_per(n, 1'b0, wc, saw);
                wait_tick(t1); wait_tick(t2); wait_tick(t3);
                check(rq, t2 - t1, n);
                check(rq, t3 - t2, n);
            end

            // R4: deferred write mid-period (N 12 -> 5)
            wait_tick(t);
            repeat (3) @(negedge clk);
            write_per(5, 1'b0, wc, saw);
            wait_tick(t1);
            check("R4 old period kept", t1 - t, 12);
            wait_tick(t2);
            check("R4 new period", t2 - t1, 5);

            // R6: deferred write on the wrap cycle (N 5 -> 9)
            wait_tick(t);
            repeat (4) @(negedge clk);
            write_per(9, 1'b0, wc, saw);
            check("R6 pulse at wrap kept", int'(saw), 1);
            check("R6 wrap cycle", wc, t + 5);
            wait_tick(t1);
            check("R6 new period next", t1 - wc, 9);

            // R10: ratios 0 and 1 clamp to 2
            for (int z = 0; z < 2; z++) begin
                write_per(z, 1'b0, wc, saw);
                wait_tick(t1); wait_tick(t2); wait_tick(t3);
                check("R10 clamp", t2 - t1, 2);
                check("R10 clamp", t3 - t2, 2);
            end

            if (s < 2) begin
                // R5: immediate writes reload the counter
                wait_tick(t);
                write_per(6, 1'b1, wc, saw);
                wait_tick(t1);
                check("R5 immediate shorter", t1 - wc, 6);
                wait_tick(t2);
                check("R5 following period", t2 - t1, 6);
                repeat (2) @(negedge clk);
                write_per(15, 1'b1, wc, saw);
                wait_tick(t1);
                check("R5 immediate longer", t1 - wc, 15);
                // R6: immediate write on the wrap cycle
                wait_tick(t);
                repeat (14) @(negedge clk);
                write_per(4, 1'b1, wc, saw);
                check("R6 immediate at wrap pulse", int'(saw), 1);
                wait_tick(t1);
                check("R6 immediate at wrap period", t1 - wc, 4);
            end else begin
                // R7: immediate shrink below the current count
                write_per(20, 1'b0, wc, saw);
                wait_tick(t);
                wait_tick(t);
                repeat (12) @(negedge clk);
                write_per(4, 1'b1, wc, saw);
                wait_tick(t1);
                check("R7 wrap on next cycle", t1 - wc, 1);
                wait_tick(t2);
                check("R7 new limit period", t2 - t1, 4);
            end

            // R8: pause for 6 cycles with a write during the pause
            apply_now = 1'b0;
            write_per(8, 1'b0, wc, saw);
            wait_tick(t);
            wait_tick(t);
            repeat (2) @(negedge clk);
            cnt_en = 1'b0;
            write_per(5, 1'b0, wc, saw);
            hits = int'(saw);
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (tick === 1'b1) hits++;
            end
            cnt_en = 1'b1;
            check("R8 no pulse while paused", hits, 0);
            wait_tick(t1);
            check("R8 paused period stretched", t1 - t, 14);
            wait_tick(t2);
            check("R8 write accepted while paused", t2 - t1, 5);

            // R8: long pause produces no pulse
            cnt_en = 1'b0;
            hits = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (tick === 1'b1) hits++;
            end
            cnt_en = 1'b1;
            check("R8 long pause silent", hits, 0);
        end

        check("R11 no adjacent pulses", wide, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule